// File: doc/BRIEF.md
# Two-Stage Integrating Converter Sequencer

This block is the digital controller of a small charge-counting converter that digitises a voltage held on a shared sense line. It does no analog work itself. It sets the reference levels of two comparators, reads their outputs, and drives the strobes of a dummy cell that moves a fixed packet of charge onto the line or off it. From this it builds a 5-bit result. The two upper bits give a coarse quarter-scale class. The three lower bits give the number of charge packets that were needed to carry the line across the nearest class boundary.

A conversion starts with a pulse on `start`. The coarse stage (states COARSE1 and COARSE2) tests the line against quarter, three-quarter and, when needed, half scale. The fine stage alternates FINE_PCH and FINE_PUMP. It pumps charge up toward the boundary above for the two lower classes and down toward the boundary below for the two upper classes. It stops when the watched comparator flips or when the count reaches its limit. The DONE state raises `done` for one cycle and then returns to IDLE.

The state transitions are as follows. IDLE→COARSE1 on start. COARSE1→FINE_PCH when both comparators agree, otherwise COARSE1→COARSE2. COARSE2→FINE_PCH. FINE_PCH→DONE on a flip or on saturation, otherwise FINE_PCH→FINE_PUMP. FINE_PUMP→FINE_PCH. DONE→IDLE. Each coarse state holds for two cycles, because the comparators get one cycle to settle before they are sampled.

Top module: `twostage_adc_seq`

## Requirements
- R1: During and after reset, all enables, strobes and `done` are low, and `code` is 0.
- R2: COARSE1 enables both comparators. It drives the N reference with code 2 (three-quarter scale) and the P reference with code 0 (quarter scale), and samples them in its second cycle. Reference codes are 0 = 1/4, 1 = 1/2, 2 = 3/4 of full scale.
- R3: In COARSE1, both outputs low selects class 0. Both outputs high selects class 3.
- R4: When the two outputs disagree, COARSE2 sets both references to code 1. Both outputs high then selects class 2, and any other result selects class 1.
- R5: Classes 0 and 1 enable only the P comparator, with reference code 0 or 1 respectively, and use `pch_in`. The fine stage ends when `comp_p` reads high.
- R6: Classes 2 and 3 enable only the N comparator, with reference code 1 or 2 respectively, and use `pch_out`. The fine stage ends when `comp_n` reads low.
- R7: Each pump cycle is one precharge cycle followed by one wordline cycle. A precharge strobe never overlaps `pump_wl`, and `pch_in` never overlaps `pch_out`.
- R8: `code` = class × 8 + number of wordline pulses issued. The class occupies bits [4:3] and the count occupies bits [2:0].
- R9: After 7 pulses without a flip, the count stays at 7 and the conversion finishes.
- R10: `done` is high for exactly one cycle per conversion. `code` changes only in that cycle and holds its value until the next conversion finishes.
- R11: `start` pulses that arrive while a conversion is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a conversion (sampled in IDLE) |
| comp_n | input | 1 | N comparator output, high when the line is above its reference |
| comp_p | input | 1 | P comparator output, high when the line is above its reference |
| ref_sel_n | output | 2 | N comparator reference code |
| ref_sel_p | output | 2 | P comparator reference code |
| cmp_en_n | output | 1 | N comparator enable |
| cmp_en_p | output | 1 | P comparator enable |
| pch_in | output | 1 | Dummy-cell precharge strobe for pumping charge in |
| pch_out | output | 1 | Dummy-cell precharge strobe for pumping charge out |
| pump_wl | output | 1 | Dummy-cell wordline strobe that transfers charge |
| done | output | 1 | One-cycle completion pulse |
| code | output | 5 | Conversion result {class, count} |

## Verification
The bench uses the default widths: a 3-bit count and a 2-bit class. It models the line on a 32-step scale in which one pump moves the line by one step, and places the references at steps 8, 16 and 24. On this scale every class, each exact boundary (8, 16, 24) and saturation at both ends of the range (0, 9, 24, 31) all fall within a few dozen cycles. The bench checks each result against a value computed from the line level. It also compares the number of wordline pulses it counts with the low bits of the code.

// File: rtl/tsadc_pkg.sv
package tsadc_pkg;
    typedef enum logic [2:0] {
        IDLE,
        COARSE1,
        COARSE2,
        FINE_PCH,
        FINE_PUMP,
        DONE
    } tsadc_state_t;

    localparam int REF_W = 2;
    localparam logic [REF_W-1:0] REF_QTR  = 2'd0;
    localparam logic [REF_W-1:0] REF_HALF = 2'd1;
    localparam logic [REF_W-1:0] REF_3QTR = 2'd2;

    localparam int CLS_W = 2;
    localparam logic [CLS_W-1:0] CLS_LOW   = 2'd0;
    localparam logic [CLS_W-1:0] CLS_MIDLO = 2'd1;
    localparam logic [CLS_W-1:0] CLS_MIDHI = 2'd2;
    localparam logic [CLS_W-1:0] CLS_HIGH  = 2'd3;
endpackage

// File: rtl/tsadc_coarse_decide.sv
module tsadc_coarse_decide
    import tsadc_pkg::*;
(
    input  logic             second_look,
    input  logic             comp_n,
    input  logic             comp_p,
    output logic             need_more,
    output logic [CLS_W-1:0] cls
);
    always_comb begin
        need_more = 1'b0;
        cls       = CLS_LOW;
        if (!second_look) begin
            if (!comp_n && !comp_p)     cls = CLS_LOW;
            else if (comp_n && comp_p)  cls = CLS_HIGH;
            else                        need_more = 1'b1;
        end else begin
            cls = (comp_n && comp_p) ? CLS_MIDHI : CLS_MIDLO;
        end
    end
endmodule

// File: rtl/tsadc_fine_count.sv
module tsadc_fine_count #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             at_max
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assign at_max = (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n || clr)        cnt <= '0;
        else if (inc && !at_max)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/twostage_adc_seq.sv
module twostage_adc_seq
    import tsadc_pkg::*;
#(
    parameter int CNT_W  = 3,
    parameter int CODE_W = CLS_W + CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              comp_n,
    input  logic              comp_p,
    output logic [REF_W-1:0]  ref_sel_n,
    output logic [REF_W-1:0]  ref_sel_p,
    output logic              cmp_en_n,
    output logic              cmp_en_p,
    output logic              pch_in,
    output logic              pch_out,
    output logic              pump_wl,
    output logic              done,
    output logic [CODE_W-1:0] code
);
    tsadc_state_t     state, nxt;
    logic             settled;
    logic [CLS_W-1:0] cls_q;
    logic [CODE_W-1:0] code_q;

    logic             need_more;
    logic [CLS_W-1:0] cls_dec;
    logic [CNT_W-1:0] cnt;
    logic             at_max;
    logic             pump_up;
    logic             flipped;

    tsadc_coarse_decide u_decide (
        .second_look (state == COARSE2),
        .comp_n      (comp_n),
        .comp_p      (comp_p),
        .need_more   (need_more),
        .cls         (cls_dec)
    );

    tsadc_fine_count #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state == IDLE),
        .inc    (state == FINE_PUMP),
        .cnt    (cnt),
        .at_max (at_max)
    );

    assign pump_up = (cls_q == CLS_LOW) || (cls_q == CLS_MIDLO);
    assign flipped = pump_up ? comp_p : !comp_n;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            IDLE:      if (start) nxt = COARSE1;
            COARSE1:   if (settled) nxt = need_more ? COARSE2 : FINE_PCH;
            COARSE2:   if (settled) nxt = FINE_PCH;
            FINE_PCH:  nxt = (flipped || at_max) ? DONE : FINE_PUMP;
            FINE_PUMP: nxt = FINE_PCH;
            DONE:      nxt = IDLE;
            default:   nxt = IDLE;
        endcase
    end

    // state register and held results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= IDLE;
            settled <= 1'b0;
            cls_q   <= CLS_LOW;
            code_q  <= '0;
        end else begin
            state <= nxt;
            if ((state == COARSE1) || (state == COARSE2)) begin
                settled <= !settled;
                if (settled && !need_more) cls_q <= cls_dec;
            end else begin
                settled <= 1'b0;
            end
            if ((state == FINE_PCH) && (nxt == DONE)) code_q <= {cls_q, cnt};
        end
    end

    // output decode
    always_comb begin
        ref_sel_n = REF_3QTR;
        ref_sel_p = REF_QTR;
        cmp_en_n  = 1'b0;
        cmp_en_p  = 1'b0;
        pch_in    = 1'b0;
        pch_out   = 1'b0;
        pump_wl   = 1'b0;
        done      = 1'b0;
        unique case (state)
            IDLE: ;
            COARSE1: begin
                cmp_en_n = 1'b1;
                cmp_en_p = 1'b1;
            end
            COARSE2: begin
                ref_sel_n = REF_HALF;
                ref_sel_p = REF_HALF;
                cmp_en_n  = 1'b1;
                cmp_en_p  = 1'b1;
            end
            FINE_PCH, FINE_PUMP: begin
                ref_sel_p = (cls_q == CLS_LOW)   ? REF_QTR  : REF_HALF;
                ref_sel_n = (cls_q == CLS_MIDHI) ? REF_HALF : REF_3QTR;
                cmp_en_p  = pump_up;
                cmp_en_n  = !pump_up;
                pch_in    = (state == FINE_PCH) && pump_up;
                pch_out   = (state == FINE_PCH) && !pump_up;
                pump_wl   = (state == FINE_PUMP);
            end
            DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign code = code_q;
endmodule

// File: rtl/twostage_adc_seq_chk.sv
module twostage_adc_seq_chk #(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_en_n,
    input logic              cmp_en_p,
    input logic              pch_in,
    input logic              pch_out,
    input logic              pump_wl,
    input logic              done,
    input logic [CODE_W-1:0] code
);
    // R7
    wl_pch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pump_wl |-> !(pch_in || pch_out));
    // R7
    pch_pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pch_in && pch_out));
    // R7
    wl_after_pch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_wl) |-> $past(pch_in || pch_out));
    // R5
    pump_in_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pch_in |-> (cmp_en_p && !cmp_en_n));
    // R6
    pump_out_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pch_out |-> (cmp_en_n && !cmp_en_p));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(code));
endmodule

bind twostage_adc_seq twostage_adc_seq_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_en_n (cmp_en_n),
    .cmp_en_p (cmp_en_p),
    .pch_in   (pch_in),
    .pch_out  (pch_out),
    .pump_wl  (pump_wl),
    .done     (done),
    .code     (code)
);

// File: tb/twostage_adc_seq_bench.sv
module twostage_adc_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       comp_n, comp_p;
    logic [1:0] ref_sel_n, ref_sel_p;
    logic       cmp_en_n, cmp_en_p, pch_in, pch_out, pump_wl, done;
    logic [4:0] code;

    int line_lvl = 0;
    int pumps = 0;
    int dones = 0;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = !clk;

    twostage_adc_seq u_twostage_adc_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .comp_n(comp_n), .comp_p(comp_p),
        .ref_sel_n(ref_sel_n), .ref_sel_p(ref_sel_p),
        .cmp_en_n(cmp_en_n), .cmp_en_p(cmp_en_p),
        .pch_in(pch_in), .pch_out(pch_out), .pump_wl(pump_wl),
        .done(done), .code(code)
    );

    function automatic int thr(input logic [1:0] r);
        return (r == 2'd0) ? 8 : (r == 2'd1) ? 16 : 24;
    endfunction

    assign comp_p = (line_lvl > thr(ref_sel_p));
    assign comp_n = (line_lvl > thr(ref_sel_n));

    always @(posedge clk) begin
        if (pump_wl) begin
            line_lvl <= cmp_en_p ? line_lvl + 1 : line_lvl - 1;
            pumps    <= pumps + 1;
        end
        if (done) dones <= dones + 1;
    end

    function automatic int expect_code(input int l);
        int c, n;
        if (l <= 8)       begin c = 0; n = 9 - l;  end
        else if (l > 24)  begin c = 3; n = l - 24; end
        else if (l > 16)  begin c = 2; n = l - 16; end
        else              begin c = 1; n = 17 - l; end
        if (n > 7) n = 7;
        return c * 8 + n;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one conversion from level l; optionally pulses start mid-run
    task automatic convert(input int l, input string req, input bit extra_start);
        int waited;
        @(negedge clk);
        line_lvl = l;
        pumps = 0;
        dones = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (extra_start) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 100) begin
            @(negedge clk);
            waited++;
        end
        check({req, " code"}, int'(code), expect_code(l));
        check("R8 pulse count", pumps, expect_code(l) % 8);
        @(negedge clk);
        check("R10 done width", int'(done), 0);
        repeat (10) @(negedge clk);
        check("R10 done count / R11 restart ignored", dones, 1);
        check("R10 code held", int'(code), expect_code(l));
    endtask

    task automatic test_reset;
        check("R1 done", int'(done), 0);
        check("R1 strobes", int'({pch_in, pch_out, pump_wl, cmp_en_n, cmp_en_p}), 0);
        check("R1 code", int'(code), 0);
    endtask

    task automatic test_coarse_refs;
        @(negedge clk);
        line_lvl = 12;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 enables", int'({cmp_en_n, cmp_en_p}), 3);
        check("R2 ref n", int'(ref_sel_n), 2);
        check("R2 ref p", int'(ref_sel_p), 0);
        repeat (2) @(negedge clk);
        check("R4 ref n", int'(ref_sel_n), 1);
        check("R4 ref p", int'(ref_sel_p), 1);
        repeat (2) @(negedge clk);
        check("R5 p only", int'({cmp_en_n, cmp_en_p}), 1);
        check("R5 ref p", int'(ref_sel_p), 1);
        check("R5 pch_in", int'(pch_in), 1);
        @(negedge clk);
        check("R7 wordline", int'({pump_wl, pch_in}), 2);
        repeat (30) @(negedge clk);
    endtask

    task automatic test_pump_out_dir;
        @(negedge clk);
        line_lvl = 28;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 n only", int'({cmp_en_n, cmp_en_p}), 2);
        check("R6 ref n", int'(ref_sel_n), 2);
        check("R6 pch_out", int'(pch_out), 1);
        repeat (30) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_coarse_refs();
        test_pump_out_dir();
        convert(5,  "R3 R5 class0", 1'b0);
        convert(8,  "R3 boundary 8", 1'b0);
        convert(0,  "R9 saturate low", 1'b0);
        convert(28, "R3 R6 class3", 1'b0);
        convert(31, "R9 saturate high", 1'b0);
        convert(12, "R4 class1", 1'b0);
        convert(16, "R4 boundary 16", 1'b0);
        convert(9,  "R9 class1 saturate", 1'b0);
        convert(20, "R4 R6 class2", 1'b0);
        convert(24, "R9 boundary 24", 1'b0);
        convert(17, "R4 class2 edge", 1'b0);
        convert(6,  "R11 restart", 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule